// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block sits between a host processor and the engines of a floppy disk controller. A 2-bit offset selects one of four byte registers. Offset 0 reads back the status byte and takes a command byte on write. Offsets 1, 2 and 3 hold the track, sector and data bytes. Every command byte is sorted into one of four kinds. The stepping kind, the sector-transfer kind and the track-transfer kind start an engine. The fourth kind aborts whatever is running and arms interrupt conditions.

The status byte keeps busy, data request, CRC error, record-not-found and motor-on in fixed places. The other three bits change their meaning with the kind of the last started command. Some status bits become valid only after a density-dependent delay, so a settle window follows every accepted command. Within it the status byte does not change.

Engines report through plain pulse and level inputs. Bytes from the disk side arrive on a valid/ready stream. A byte moves when `eng_in_valid` and `eng_in_ready` are both high at a clock edge. Ready is high only while no data request is pending, so the engine keeps the byte and valid held until the host has taken the previous byte. `eng_in_valid` may fall without a transfer.

Top module: `fdc_hostregs`

## Requirements
- R1: After reset, busy, drq, intrq, cmd_start and cmd_abort are 0, the track, sector and data registers are 0, `eng_in_ready` is 1, and with every drive flag low and `head_at_trk0` high the status byte reads 0x00.
- R2: Writes to offsets 1, 2 and 3 load the track, sector and data registers, and reads return them. A pulse on `eng_trk_we` loads `eng_trk_val` into the track register and takes priority over a host write in the same cycle.
- R3: Bits 7:4 of a command set its kind on `cmd_kind`: 0xxx gives 0 (step), 100x and 101x give 1 (sector transfer), 1100, 1110 and 1111 give 2 (track transfer), and 1101 gives 3 (abort). A kind 0 to 2 command accepted while idle sets busy and gives a one-cycle `cmd_start` pulse in the cycle after the write, with the byte on `cmd_code`.
- R4: Status bit 0 is busy, bit 1 is data request, bit 3 is CRC error, bit 4 is record not found and bit 7 is motor on, whatever the kind of the last command.
- R5: After a kind 0 command, status bit 2 is the inverse of `head_at_trk0`, bit 5 is `spun_up` and bit 6 is 0.
- R6: After a kind 1 or 2 command, status bit 2 is `lost_data`, bit 5 is `deleted_mark` (0 normal, 1 deleted) and bit 6 is `wr_protect`.
- R7: A kind 0 to 2 command written while busy is ignored. It gives no `cmd_start`, and busy and the status view stay as they were.
- R8: An abort command is taken at any time. It clears busy and, if busy was set, gives a one-cycle `cmd_abort` pulse. With command bits 3:0 all zero it leaves intrq low.
- R9: An abort command with bit 3 set raises intrq at once.
- R10: An abort command with bit 2 set arms an interrupt on every rising edge of `index_pulse`. The arming stays until the next abort command replaces it.
- R11: An abort command with bit 1 set arms an interrupt on a falling edge of `drv_ready`, and bit 0 arms one on a rising edge. The arming stays until the next abort command.
- R12: A command that finishes (`eng_done` while busy) clears busy and raises intrq. A status read clears intrq, and so does any accepted command. A new interrupt event in the same cycle wins over the clear.
- R13: drq is set by `eng_need`, or by a byte accepted on the input stream, which also loads the data register. A host read or write of offset 3, or an accepted kind 0 to 2 command, clears drq, and a set in the same cycle wins. `eng_in_ready` equals not drq.
- R14: When a command is accepted, status bit 0 takes the new busy value at once. Bits 7:1 keep the value they had before the write. All bits then hold for SETTLE_SD cycles when `sd_mode` is 1, or for SETTLE_DD cycles when it is 0, before they follow the drive again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Host access select |
| bus_rd | input | 1 | Host read strobe (one cycle) |
| bus_wr | input | 1 | Host write strobe (one cycle) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the selected offset |
| sd_mode | input | 1 | 1 = single density, which gives the longer settle window |
| motor_on | input | 1 | Motor running flag |
| wr_protect | input | 1 | Disk write protected |
| deleted_mark | input | 1 | Last data mark was deleted |
| spun_up | input | 1 | Spin-up completed |
| rec_not_found | input | 1 | Record not found |
| crc_error | input | 1 | CRC error |
| lost_data | input | 1 | Lost data byte |
| head_at_trk0 | input | 1 | Head is at track 0 |
| index_pulse | input | 1 | Index hole sensor |
| drv_ready | input | 1 | Drive ready level |
| eng_done | input | 1 | Engine finished the command |
| eng_need | input | 1 | Engine needs a byte from the host |
| eng_in_valid | input | 1 | Disk byte valid |
| eng_in_data | input | 8 | Disk byte |
| eng_in_ready | output | 1 | Data register free for a disk byte |
| eng_trk_we | input | 1 | Engine track register load |
| eng_trk_val | input | 8 | Engine track value |
| cmd_start | output | 1 | Start pulse for the engines |
| cmd_kind | output | 2 | Kind of the last accepted command |
| cmd_code | output | 8 | Last accepted command byte |
| cmd_abort | output | 1 | Abort pulse for the running engine |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| trk_reg | output | 8 | Track register |
| sec_reg | output | 8 | Sector register |
| dat_reg | output | 8 | Data register |

## Verification
The bench builds the block with SETTLE_SD = 12 and SETTLE_DD = 6. With these values, both settle windows open and expire within a few dozen cycles. The windows also differ enough that one sample, taken nine cycles after a command, shows the held value in single density and the updated one in double density. The short windows also let the bench run every status view, interrupt source and stream back-pressure case one after another in a single run.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CK_STEP  = 2'd0,
    CK_XFER  = 2'd1,
    CK_TRACK = 2'd2,
    CK_ABORT = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic motor;
    logic wprot;
    logic deleted;
    logic spun;
    logic rnf;
    logic crc;
    logic lost;
    logic at_trk0;
  } drive_flags_t;
endpackage

// File: rtl/fdc_cmd_class.sv
module fdc_cmd_class
  import fdc_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output cmd_kind_e         kind
);
  always_comb begin
    casez (code[7:4])
      4'b0???: kind = CK_STEP;
      4'b10??: kind = CK_XFER;
      4'b1101: kind = CK_ABORT;
      default: kind = CK_TRACK;
    endcase
  end
endmodule

// File: rtl/fdc_stat_view.sv
module fdc_stat_view
  import fdc_pkg::*;
#(
  parameter int unsigned SETTLE_SD = 48,
  parameter int unsigned SETTLE_DD = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              view_xfer,
  input  drive_flags_t      flags,
  input  logic              drq,
  input  logic              busy,
  input  logic              cmd_acc,
  input  logic              busy_next,
  input  logic              sd_mode,
  output logic [BYTE_W-1:0] stat
);
  localparam int unsigned MAX_SETTLE = (SETTLE_SD > SETTLE_DD) ? SETTLE_SD : SETTLE_DD;
  localparam int unsigned CNT_W      = $clog2(MAX_SETTLE + 1) < 1 ? 1 : $clog2(MAX_SETTLE + 1);

  logic [BYTE_W-1:0] live;

  always_comb begin
    live[7] = flags.motor;
    live[6] = view_xfer ? flags.wprot : 1'b0;
    live[5] = view_xfer ? flags.deleted : flags.spun;
    live[4] = flags.rnf;
    live[3] = flags.crc;
    live[2] = view_xfer ? flags.lost : ~flags.at_trk0;
    live[1] = drq;
    live[0] = busy;
  end

  generate
    if (MAX_SETTLE == 0) begin : g_direct
      assign stat = live;
    end else begin : g_settle
      logic [CNT_W-1:0]  cnt_q;
      logic [BYTE_W-1:0] stat_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          stat_q <= '0;
        end else if (cmd_acc) begin
          cnt_q  <= sd_mode ? CNT_W'(SETTLE_SD) : CNT_W'(SETTLE_DD);
          stat_q <= {stat_q[7:1], busy_next};
        end else if (cnt_q != '0) begin
          cnt_q  <= cnt_q - 1'b1;
        end else begin
          stat_q <= live;
        end
      end
      assign stat = stat_q;
    end
  endgenerate
endmodule

// File: rtl/fdc_irq_ctl.sv
module fdc_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_acc,
  input  logic [3:0] abort_bits,
  input  logic       go_acc,
  input  logic       done_evt,
  input  logic       stat_rd,
  input  logic       index_pulse,
  input  logic       drv_ready,
  output logic       intrq
);
  localparam int unsigned N_COND = 3;

  logic [N_COND-1:0] arm_q;
  logic [N_COND-1:0] lvl_now;
  logic [N_COND-1:0] lvl_q;
  logic [N_COND-1:0] want_rise;
  logic [N_COND-1:0] evt;
  logic              set_irq;
  logic              clr_irq;

  // condition order: [2] index rise, [1] ready fall, [0] ready rise
  assign lvl_now   = {index_pulse, drv_ready, drv_ready};
  assign want_rise = 3'b101;

  genvar gi;
  generate
    for (gi = 0; gi < N_COND; gi++) begin : g_edge
      assign evt[gi] = want_rise[gi] ? (lvl_now[gi] & ~lvl_q[gi])
                                     : (~lvl_now[gi] & lvl_q[gi]);
    end
  endgenerate

  assign set_irq = (abort_acc & abort_bits[3]) | done_evt | (|(arm_q & evt));
  assign clr_irq = stat_rd | go_acc | abort_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= '0;
      lvl_q <= '0;
      intrq <= 1'b0;
    end else begin
      lvl_q <= lvl_now;
      if (abort_acc) arm_q <= abort_bits[2:0];
      if (set_irq)      intrq <= 1'b1;
      else if (clr_irq) intrq <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_hostregs.sv
module fdc_hostregs
  import fdc_pkg::*;
#(
  parameter int unsigned SETTLE_SD = 48,
  parameter int unsigned SETTLE_DD = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cs,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sd_mode,
  input  logic       motor_on,
  input  logic       wr_protect,
  input  logic       deleted_mark,
  input  logic       spun_up,
  input  logic       rec_not_found,
  input  logic       crc_error,
  input  logic       lost_data,
  input  logic       head_at_trk0,
  input  logic       index_pulse,
  input  logic       drv_ready,
  input  logic       eng_done,
  input  logic       eng_need,
  input  logic       eng_in_valid,
  input  logic [7:0] eng_in_data,
  output logic       eng_in_ready,
  input  logic       eng_trk_we,
  input  logic [7:0] eng_trk_val,
  output logic       cmd_start,
  output logic [1:0] cmd_kind,
  output logic [7:0] cmd_code,
  output logic       cmd_abort,
  output logic       busy,
  output logic       drq,
  output logic       intrq,
  output logic [7:0] trk_reg,
  output logic [7:0] sec_reg,
  output logic [7:0] dat_reg
);
  localparam logic [1:0] OFS_CMD = 2'd0;
  localparam logic [1:0] OFS_TRK = 2'd1;
  localparam logic [1:0] OFS_SEC = 2'd2;
  localparam logic [1:0] OFS_DAT = 2'd3;

  cmd_kind_e    wr_kind;
  cmd_kind_e    kind_q;
  drive_flags_t flags;
  logic         wr_any, rd_any, cmd_wr, go_acc, abort_acc, done_evt, in_acc;
  logic         busy_q, busy_nx, drq_q, view_xfer_q, start_q, abort_q;
  logic [7:0]   code_q, trk_q, sec_q, dat_q, stat;

  assign wr_any    = bus_cs & bus_wr;
  assign rd_any    = bus_cs & bus_rd;
  assign cmd_wr    = wr_any & (bus_addr == OFS_CMD);

  fdc_cmd_class u_class (
    .code (bus_wdata),
    .kind (wr_kind)
  );

  assign abort_acc = cmd_wr & (wr_kind == CK_ABORT);
  assign go_acc    = cmd_wr & (wr_kind != CK_ABORT) & ~busy_q;
  assign done_evt  = eng_done & busy_q & ~abort_acc;
  assign in_acc    = eng_in_valid & ~drq_q;

  always_comb begin
    busy_nx = busy_q;
    if (go_acc)                     busy_nx = 1'b1;
    else if (abort_acc || done_evt) busy_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      start_q     <= 1'b0;
      abort_q     <= 1'b0;
      code_q      <= '0;
      kind_q      <= CK_STEP;
      view_xfer_q <= 1'b0;
    end else begin
      busy_q  <= busy_nx;
      start_q <= go_acc;
      abort_q <= abort_acc & busy_q;
      if (go_acc) begin
        code_q      <= bus_wdata;
        kind_q      <= wr_kind;
        view_xfer_q <= (wr_kind != CK_STEP);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
    end else if (eng_need || in_acc) begin
      drq_q <= 1'b1;
    end else if (((rd_any || wr_any) && bus_addr == OFS_DAT) || go_acc) begin
      drq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q <= '0;
      sec_q <= '0;
      dat_q <= '0;
    end else begin
      if (eng_trk_we)                              trk_q <= eng_trk_val;
      else if (wr_any && bus_addr == OFS_TRK)      trk_q <= bus_wdata;
      if (wr_any && bus_addr == OFS_SEC)           sec_q <= bus_wdata;
      if (in_acc)                                  dat_q <= eng_in_data;
      else if (wr_any && bus_addr == OFS_DAT)      dat_q <= bus_wdata;
    end
  end

  assign flags = '{motor: motor_on, wprot: wr_protect, deleted: deleted_mark,
                   spun: spun_up, rnf: rec_not_found, crc: crc_error,
                   lost: lost_data, at_trk0: head_at_trk0};

  fdc_stat_view #(
    .SETTLE_SD (SETTLE_SD),
    .SETTLE_DD (SETTLE_DD)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .view_xfer (view_xfer_q),
    .flags     (flags),
    .drq       (drq_q),
    .busy      (busy_q),
    .cmd_acc   (go_acc | abort_acc),
    .busy_next (busy_nx),
    .sd_mode   (sd_mode),
    .stat      (stat)
  );

  fdc_irq_ctl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_acc   (abort_acc),
    .abort_bits  (bus_wdata[3:0]),
    .go_acc      (go_acc),
    .done_evt    (done_evt),
    .stat_rd     (rd_any & (bus_addr == OFS_CMD)),
    .index_pulse (index_pulse),
    .drv_ready   (drv_ready),
    .intrq       (intrq)
  );

  always_comb begin
    case (bus_addr)
      OFS_CMD: bus_rdata = stat;
      OFS_TRK: bus_rdata = trk_q;
      OFS_SEC: bus_rdata = sec_q;
      default: bus_rdata = dat_q;
    endcase
  end

  assign eng_in_ready = ~drq_q;
  assign cmd_start    = start_q;
  assign cmd_kind     = kind_q;
  assign cmd_code     = code_q;
  assign cmd_abort    = abort_q;
  assign busy         = busy_q;
  assign drq          = drq_q;
  assign trk_reg      = trk_q;
  assign sec_reg      = sec_q;
  assign dat_reg      = dat_q;
endmodule

// File: rtl/fdc_hostregs_chk.sv
module fdc_hostregs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_cs,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       eng_done,
  input logic       eng_need,
  input logic       eng_in_valid,
  input logic [7:0] eng_in_data,
  input logic       eng_in_ready,
  input logic       cmd_start,
  input logic [1:0] cmd_kind,
  input logic       cmd_abort,
  input logic       busy,
  input logic       drq,
  input logic       intrq,
  input logic [7:0] dat_reg
);
  logic cmd_wr_c, abort_wr_c;
  assign cmd_wr_c   = bus_cs && bus_wr && bus_addr == 2'd0;
  assign abort_wr_c = cmd_wr_c && bus_wdata[7:4] == 4'hD;

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy && cmd_kind != 2'd3); // R3
  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr_c && !abort_wr_c) |=> !cmd_start); // R7
  AST_ABORT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr_c |=> !busy); // R8
  AST_ABORT_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> !busy); // R8
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && !abort_wr_c) |=> intrq && !busy); // R12
  AST_DRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && (bus_rd || bus_wr) && bus_addr == 2'd3 && !eng_need
     && !(eng_in_valid && eng_in_ready)) |=> !drq); // R13
  AST_STREAM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_in_valid && eng_in_ready) |=> drq && dat_reg == $past(eng_in_data)); // R13
endmodule

bind fdc_hostregs fdc_hostregs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_cs       (bus_cs),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .eng_done     (eng_done),
  .eng_need     (eng_need),
  .eng_in_valid (eng_in_valid),
  .eng_in_data  (eng_in_data),
  .eng_in_ready (eng_in_ready),
  .cmd_start    (cmd_start),
  .cmd_kind     (cmd_kind),
  .cmd_abort    (cmd_abort),
  .busy         (busy),
  .drq          (drq),
  .intrq        (intrq),
  .dat_reg      (dat_reg)
);

// File: tb/sim_fdc_hostregs.sv
module sim_fdc_hostregs;
  localparam int CLK_PERIOD = 10;
  localparam int SD_WIN = 12;
  localparam int DD_WIN = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sd_mode = 0, motor_on = 0, wr_protect = 0, deleted_mark = 0, spun_up = 0;
  logic rec_not_found = 0, crc_error = 0, lost_data = 0, head_at_trk0 = 1;
  logic index_pulse = 0, drv_ready = 0, eng_done = 0, eng_need = 0;
  logic eng_in_valid = 0, eng_trk_we = 0, eng_in_ready;
  logic [7:0] eng_in_data = 0, eng_trk_val = 0;
  logic cmd_start, cmd_abort, busy, drq, intrq;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_code, trk_reg, sec_reg, dat_reg;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rd_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_hostregs #(.SETTLE_SD(SD_WIN), .SETTLE_DD(DD_WIN)) u0 (.*);

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic finish_cmd();
    eng_done = 1; tick(); eng_done = 0;
    bus_read(2'd0, rd_v);
    tick(DD_WIN + 3);
  endtask

  task automatic set_flags(input logic [7:0] f);
    {motor_on, wr_protect, deleted_mark, spun_up, rec_not_found, crc_error,
     lost_data, head_at_trk0} = f;
  endtask

  task automatic t_reset();
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 drq", {7'd0, drq}, 8'd0);
    chk("R1 intrq", {7'd0, intrq}, 8'd0);
    chk("R1 start/abort", {6'd0, cmd_start, cmd_abort}, 8'd0);
    chk("R1 in_ready", {7'd0, eng_in_ready}, 8'd1);
    chk("R1 regs", trk_reg | sec_reg | dat_reg, 8'd0);
    bus_read(2'd0, rd_v); chk("R1 status", rd_v, 8'h00);
  endtask

  task automatic t_regs();
    bus_write(2'd1, 8'h27); bus_write(2'd2, 8'h09); bus_write(2'd3, 8'hA5);
    bus_read(2'd1, rd_v); chk("R2 track", rd_v, 8'h27);
    bus_read(2'd2, rd_v); chk("R2 sector", rd_v, 8'h09);
    bus_read(2'd3, rd_v); chk("R2 data", rd_v, 8'hA5);
    eng_trk_we = 1; eng_trk_val = 8'h4B;
    bus_cs = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h11;
    tick(); bus_cs = 0; bus_wr = 0; eng_trk_we = 0;
    bus_read(2'd1, rd_v); chk("R2 engine track wins", rd_v, 8'h4B);
  endtask

  task automatic t_classify();
    logic [7:0] codes [11] = '{8'h00, 8'h1F, 8'h35, 8'h7F, 8'h80, 8'h9C,
                               8'hA0, 8'hBF, 8'hC4, 8'hE0, 8'hF4};
    logic [1:0] kinds [11] = '{0, 0, 0, 0, 1, 1, 1, 1, 2, 2, 2};
    for (int i = 0; i < 11; i++) begin
      bus_write(2'd0, codes[i]);
      chk("R3 start", {7'd0, cmd_start}, 8'd1);
      chk("R3 kind", {6'd0, cmd_kind}, {6'd0, kinds[i]});
      chk("R3 code", cmd_code, codes[i]);
      chk("R3 busy", {7'd0, busy}, 8'd1);
      tick(); chk("R3 start one cycle", {7'd0, cmd_start}, 8'd0);
      finish_cmd();
    end
    bus_write(2'd0, 8'hD0);
    chk("R3 abort kind no start", {6'd0, cmd_start, busy}, 8'd0);
    tick(DD_WIN + 3);
  endtask

  task automatic t_views();
    set_flags(8'b1111_1110);
    bus_write(2'd0, 8'h10); tick(DD_WIN + 3);
    bus_read(2'd0, rd_v); chk("R4 R5 step view", rd_v, 8'hBD);
    finish_cmd();
    bus_write(2'd0, 8'h88); tick(DD_WIN + 3);
    bus_read(2'd0, rd_v); chk("R4 R6 transfer view", rd_v, 8'hFD);
    set_flags(8'b1100_1101); tick(3);
    bus_read(2'd0, rd_v); chk("R6 transfer view b", rd_v, 8'hD9);
    bus_write(2'd0, 8'h00);
    chk("R7 no start while busy", {7'd0, cmd_start}, 8'd0);
    tick(DD_WIN + 3);
    bus_read(2'd0, rd_v); chk("R7 view unchanged", rd_v, 8'hD9);
    chk("R7 busy kept", {7'd0, busy}, 8'd1);
    bus_write(2'd0, 8'hD0);
    chk("R8 abort pulse", {6'd0, cmd_abort, busy}, 8'h02);
    chk("R8 silent", {7'd0, intrq}, 8'd0);
    tick(); chk("R8 pulse one cycle", {7'd0, cmd_abort}, 8'd0);
    tick(DD_WIN + 3);
    bus_read(2'd0, rd_v); chk("R4 idle view", rd_v, 8'hD8);
    set_flags(8'b0000_0001); tick(DD_WIN + 3);
  endtask

  task automatic t_done_irq();
    bus_write(2'd0, 8'h04);
    eng_done = 1; tick(); eng_done = 0;
    chk("R12 done irq", {6'd0, intrq, busy}, 8'h02);
    bus_read(2'd0, rd_v);
    chk("R12 read clears", {7'd0, intrq}, 8'd0);
    tick(DD_WIN + 3);
    bus_write(2'd0, 8'h04);
    eng_done = 1; tick(); eng_done = 0;
    tick(DD_WIN + 3);
    bus_write(2'd0, 8'h08);
    chk("R12 new command clears", {6'd0, intrq, busy}, 8'h01);
    finish_cmd();
  endtask

  task automatic t_force();
    bus_write(2'd0, 8'hD8);
    chk("R9 immediate", {7'd0, intrq}, 8'd1);
    bus_read(2'd0, rd_v);
    bus_write(2'd0, 8'hD4);
    chk("R10 armed quiet", {7'd0, intrq}, 8'd0);
    index_pulse = 1; tick(); index_pulse = 0;
    chk("R10 index 1", {7'd0, intrq}, 8'd1);
    bus_read(2'd0, rd_v); tick(3);
    index_pulse = 1; tick(); index_pulse = 0;
    chk("R10 index 2", {7'd0, intrq}, 8'd1);
    bus_read(2'd0, rd_v);
    bus_write(2'd0, 8'hD0);
    index_pulse = 1; tick(); index_pulse = 0;
    chk("R10 disarmed", {7'd0, intrq}, 8'd0);
    bus_write(2'd0, 8'hD1);
    drv_ready = 1; tick();
    chk("R11 ready rise", {7'd0, intrq}, 8'd1);
    bus_read(2'd0, rd_v);
    drv_ready = 0; tick();
    chk("R11 fall not armed", {7'd0, intrq}, 8'd0);
    bus_write(2'd0, 8'hD2);
    drv_ready = 1; tick();
    chk("R11 rise not armed", {7'd0, intrq}, 8'd0);
    drv_ready = 0; tick();
    chk("R11 ready fall", {7'd0, intrq}, 8'd1);
    bus_read(2'd0, rd_v);
    bus_write(2'd0, 8'hD0); tick(DD_WIN + 3);
  endtask

  task automatic t_drq();
    eng_need = 1; tick(); eng_need = 0;
    chk("R13 need sets", {6'd0, drq, eng_in_ready}, 8'h02);
    bus_write(2'd3, 8'h3C);
    chk("R13 write clears", {7'd0, drq}, 8'd0);
    eng_in_valid = 1; eng_in_data = 8'h5A; tick();
    chk("R13 byte taken", dat_reg, 8'h5A);
    chk("R13 drq on byte", {6'd0, drq, eng_in_ready}, 8'h02);
    eng_in_data = 8'h66; tick(2);
    chk("R13 back-pressure holds", dat_reg, 8'h5A);
    bus_read(2'd3, rd_v);
    chk("R13 read value", rd_v, 8'h5A);
    chk("R13 read clears", {7'd0, drq}, 8'd0);
    tick();
    chk("R13 next byte", dat_reg, 8'h66);
    eng_in_valid = 0;
    bus_read(2'd3, rd_v);
  endtask

  task automatic t_settle();
    sd_mode = 1;
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, rd_v); chk("R14 busy at once", rd_v & 8'h01, 8'h01);
    crc_error = 1; tick(7);
    bus_read(2'd0, rd_v); chk("R14 single density held", rd_v & 8'h08, 8'h00);
    finish_cmd(); crc_error = 0; tick(SD_WIN + 3);
    sd_mode = 0;
    bus_write(2'd0, 8'h00);
    crc_error = 1; tick(8);
    bus_read(2'd0, rd_v); chk("R14 double density updated", rd_v & 8'h08, 8'h08);
    finish_cmd(); crc_error = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(2);
    t_reset();
    t_regs();
    t_classify();
    t_views();
    t_done_irq();
    t_force();
    t_drq();
    t_settle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule